// File: doc/BRIEF.md
# Asynchronous Memory Bus Front End

This block sits between the pins of a parallel memory and its synchronous core logic. Three active-low strobes arrive asynchronously: chip enable, write enable and output enable. A fourth active-low pin holds the part in reset or power-down. Each strobe is brought into the core clock domain through a flop synchroniser. The address and data buses pass through a delay chain of the same depth, so every bus sample lines up with the strobe sample taken at the same edge.

A write cycle lasts while chip enable and write enable are both low and output enable is high. Either of the two low-going strobes can control the cycle. The address is taken from the first sample in which the write condition holds, which is the later of the two falling edges. The data is taken from the last sample in which the condition held, once either strobe has risen. At that point the block raises a single-cycle write event for the downstream command sequencer. In the same cycle, the latched address and data outputs take their new values.

The block also decides when the data pads may be driven for a read. It reports standby when the chip is deselected and the program/erase controller is idle.

Top module: `membus_if`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `addr_lat` and `data_lat` become 0, and `wr_pulse`, `dq_oe` and `standby` become 0. The synchroniser stages load the idle pin state: all strobes high and `pd_n` low.
- R2: Every pin input passes through two synchroniser flops before it is used. A pin level present at rising edge k is reflected in the registered outputs after rising edge k+2, which is the third edge that sees it.
- R3: A write condition is `ce_n`=0, `we_n`=0, `oe_n`=1 and `pd_n`=1 in one sample. The address is taken from the first sample in which the condition holds. If the strobes fall on different edges, this is the address present at the later fall.
- R4: The data word is taken from the last sample in which the write condition held. The cycle must end because `ce_n` or `we_n` rose, so a write controlled by W and a write controlled by E both complete.
- R5: Each completed write cycle produces exactly one `wr_pulse`, one clock wide. `addr_lat` and `data_lat` change only in the cycle in which `wr_pulse` is high, or when they are cleared by R1 or R9.
- R6: If a write condition ends because `oe_n` falls while `ce_n` and `we_n` are still low, no pulse is produced and the latched values are kept.
- R7: `dq_oe` is 1 only for a synchronised sample with `ce_n`=0, `oe_n`=0, `we_n`=1 and `pd_n`=1. In every other case the pads float, including whenever `ce_n`=1 or `pd_n`=0.
- R8: `standby` is 1 exactly when the synchronised `ce_n` is 1 and `ctrl_busy` was 0 at the same edge. The levels of `oe_n` and `we_n` do not affect it.
- R9: While the synchronised `pd_n` is 0, strobe activity produces no `wr_pulse`. In that state the held address, `addr_lat` and `data_lat` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low core reset |
| pd_n | input | 1 | Asynchronous reset/power-down pin, low active |
| ce_n | input | 1 | Asynchronous chip enable, low active |
| we_n | input | 1 | Asynchronous write enable, low active |
| oe_n | input | 1 | Asynchronous output enable, low active |
| ctrl_busy | input | 1 | Program/erase controller busy (core domain) |
| addr_in | input | 16 | Address bus from the pins |
| data_in | input | 16 | Data bus from the pins |
| addr_lat | output | 16 | Address of the last completed write |
| data_lat | output | 16 | Data of the last completed write |
| wr_pulse | output | 1 | One-cycle write event |
| dq_oe | output | 1 | Drive enable for the data pads |
| standby | output | 1 | Deselected and controller idle |

## Verification
Writes are run in two ways: with E held low while W pulses, and with W held low while E pulses. The address is changed at the later fall and the data is changed just after the first rise, so a swap of either edge rule shows up as a wrong latched word. A cycle aborted by output enable, back-to-back writes and writes attempted in power-down tell a correct pulse count apart from a missing, doubled or spurious one. Read, deselect and busy toggling are checked at the exact cycle predicted by the synchroniser depth, which separates a correct latency from one register too many or too few.

// File: rtl/membus_pkg.sv
// Package: shared types for the asynchronous memory bus front end.
// Assumes all pin strobes are active low.
package membus_pkg;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic pd_n;
    } strobe_t;

    localparam int STROBE_W = $bits(strobe_t);

    // Idle pin state used for reset: strobes released, power-down asserted.
    localparam strobe_t STROBE_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, pd_n: 1'b0};

endpackage

// File: rtl/membus_sync.sv
// Module: membus_sync
// A chain of STAGES flops per bit, used both as a metastability synchroniser
// for the strobes and as a matching delay line for the buses.
// Assumes STAGES >= 2. Reset is synchronous, active low, and loads RST_VAL.
module membus_sync #(
    parameter int              W       = 4,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage: sample the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                // Later stages: pass the previous stage along.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/membus_write_latch.sv
// Module: membus_write_latch
// Tracks write cycles on the synchronised strobes. It holds the address at the
// later falling strobe and takes the data at the earlier rising strobe, then
// emits one write event. Assumes the bus inputs are delayed to match the strobes.
module membus_write_latch
    import membus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  strobe_t       strb,
    input  logic [AW-1:0] addr_s,
    input  logic [DW-1:0] data_s,
    output logic [AW-1:0] addr_lat,
    output logic [DW-1:0] data_lat,
    output logic          wr_pulse
);

    logic          wr_active;
    logic          strobe_rise;
    logic          active_p;
    logic [AW-1:0] addr_hold;
    logic [DW-1:0] data_p;

    // Decode the write condition and the legal ways of ending it.
    always_comb begin
        wr_active   = !strb.ce_n && !strb.we_n && strb.oe_n;
        strobe_rise = strb.ce_n || strb.we_n;
    end

    // Keep the data sample aligned with the previous strobe sample.
    always_ff @(posedge clk) begin
        if (!rst_n) data_p <= '0;
        else        data_p <= data_s;
    end

    // Write cycle tracking, address hold and data capture.
    always_ff @(posedge clk) begin
        if (!rst_n || !strb.pd_n) begin
            active_p  <= 1'b0;
            addr_hold <= '0;
            addr_lat  <= '0;
            data_lat  <= '0;
            wr_pulse  <= 1'b0;
        end else begin
            active_p <= wr_active;
            wr_pulse <= 1'b0;
            if (wr_active && !active_p) begin
                addr_hold <= addr_s;
            end
            if (active_p && !wr_active && strobe_rise) begin
                wr_pulse <= 1'b1;
                addr_lat <= addr_hold;
                data_lat <= data_p;
            end
        end
    end

    // R5: a write event never lasts longer than one cycle.
    a_r5_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

    // R5: latched outputs move only together with a write event.
    a_r5_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_pulse && $past(strb.pd_n)) |-> ($stable(addr_lat) && $stable(data_lat)));

    // R4: a write event follows a cycle in which a write was in progress.
    a_r4_after_active: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> $past(active_p));

    // R9: power-down clears the latched values and suppresses events.
    a_r9_pd_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !strb.pd_n |=> (addr_lat == '0 && data_lat == '0 && !wr_pulse));

endmodule

// File: rtl/membus_out_ctrl.sv
// Module: membus_out_ctrl
// Decides when the data pads may be driven and when the part is in standby.
// Assumes synchronised strobes. ctrl_busy already belongs to the core domain.
module membus_out_ctrl
    import membus_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  strobe_t strb,
    input  logic    ctrl_busy,
    output logic    dq_oe,
    output logic    standby
);

    // Register the pad enable and the standby flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_oe   <= 1'b0;
            standby <= 1'b0;
        end else begin
            dq_oe   <= strb.pd_n && !strb.ce_n && !strb.oe_n && strb.we_n;
            standby <= strb.ce_n && !ctrl_busy;
        end
    end

    // R7: the pads float when the chip was deselected.
    a_r7_float_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> !$past(strb.ce_n) && $past(strb.pd_n));

    // R8: standby never coincides with a busy controller.
    a_r8_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> !$past(ctrl_busy) && $past(strb.ce_n));

endmodule

// File: rtl/membus_if.sv
// Module: membus_if (top)
// Synchronises the asynchronous memory bus strobes and buses, and feeds the
// write latch and the output control. Assumes the bus pins are stable around
// strobe edges for at least one core clock.
module membus_if
    import membus_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pd_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic          ctrl_busy,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    output logic [AW-1:0] addr_lat,
    output logic [DW-1:0] data_lat,
    output logic          wr_pulse,
    output logic          dq_oe,
    output logic          standby
);

    localparam int BUS_W = AW + DW;

    strobe_t          strb_raw;
    strobe_t          strb_s;
    logic [BUS_W-1:0] bus_raw;
    logic [BUS_W-1:0] bus_s;

    // Gather the pin strobes and the buses into vectors.
    always_comb begin
        strb_raw = '{ce_n: ce_n, we_n: we_n, oe_n: oe_n, pd_n: pd_n};
        bus_raw  = {addr_in, data_in};
    end

    membus_sync #(
        .W       (STROBE_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (STROBE_IDLE)
    ) u_strb_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (strb_raw),
        .q     (strb_s)
    );

    membus_sync #(
        .W       (BUS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ('0)
    ) u_bus_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_raw),
        .q     (bus_s)
    );

    membus_write_latch #(
        .AW (AW),
        .DW (DW)
    ) u_wlatch (
        .clk      (clk),
        .rst_n    (rst_n),
        .strb     (strb_s),
        .addr_s   (bus_s[BUS_W-1:DW]),
        .data_s   (bus_s[DW-1:0]),
        .addr_lat (addr_lat),
        .data_lat (data_lat),
        .wr_pulse (wr_pulse)
    );

    membus_out_ctrl u_outctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .strb      (strb_s),
        .ctrl_busy (ctrl_busy),
        .dq_oe     (dq_oe),
        .standby   (standby)
    );

    // R1: the core reset leaves the pads undriven.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!dq_oe && !wr_pulse && !standby));

endmodule

// File: tb/membus_if_test.sv
module membus_if_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pd_n = 1'b0;
    logic        ce_n = 1'b1;
    logic        we_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        ctrl_busy = 1'b0;
    logic [15:0] addr_in = '0;
    logic [15:0] data_in = '0;
    logic [15:0] addr_lat;
    logic [15:0] data_lat;
    logic        wr_pulse;
    logic        dq_oe;
    logic        standby;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    membus_if uut (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .ce_n(ce_n), .we_n(we_n),
        .oe_n(oe_n), .ctrl_busy(ctrl_busy), .addr_in(addr_in), .data_in(data_in),
        .addr_lat(addr_lat), .data_lat(data_lat), .wr_pulse(wr_pulse),
        .dq_oe(dq_oe), .standby(standby)
    );

    // Behavioural reference: pin history, index 0 = newest sample.
    bit          h_ce [3];
    bit          h_we [3];
    bit          h_oe [3];
    bit          h_pd [3];
    logic [15:0] h_a  [3];
    logic [15:0] h_d  [3];
    logic [15:0] m_hold, m_addr, m_data;
    bit          m_wr, m_oe, m_stby;

    function automatic bit wcond(int j);
        return !h_ce[j] && !h_we[j] && h_oe[j];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < 3; j++) begin
                h_ce[j] = 1; h_we[j] = 1; h_oe[j] = 1; h_pd[j] = 0;
                h_a[j] = '0; h_d[j] = '0;
            end
            m_hold = '0; m_addr = '0; m_data = '0;
            m_wr = 0; m_oe = 0; m_stby = 0;
        end else begin
            if (!h_pd[1]) begin
                m_hold = '0; m_addr = '0; m_data = '0; m_wr = 0;
            end else begin
                m_wr = wcond(2) && h_pd[2] && !wcond(1) && (h_ce[1] || h_we[1]);
                if (m_wr) begin
                    m_addr = m_hold;
                    m_data = h_d[2];
                end
                if (wcond(1) && !(wcond(2) && h_pd[2])) m_hold = h_a[1];
            end
            m_oe   = h_pd[1] && !h_ce[1] && !h_oe[1] && h_we[1];
            m_stby = h_ce[1] && !ctrl_busy;
            for (int j = 2; j > 0; j--) begin
                h_ce[j] = h_ce[j-1]; h_we[j] = h_we[j-1]; h_oe[j] = h_oe[j-1];
                h_pd[j] = h_pd[j-1]; h_a[j] = h_a[j-1]; h_d[j] = h_d[j-1];
            end
            h_ce[0] = ce_n; h_we[0] = we_n; h_oe[0] = oe_n; h_pd[0] = pd_n;
            h_a[0] = addr_in; h_d[0] = data_in;
        end
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare against the reference on every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3 addr_lat", addr_lat, m_addr);
            check("R4 data_lat", data_lat, m_data);
            check("R5 wr_pulse", {15'd0, wr_pulse}, {15'd0, m_wr});
            check("R7 dq_oe", {15'd0, dq_oe}, {15'd0, m_oe});
            check("R8 standby", {15'd0, standby}, {15'd0, m_stby});
            if (wr_pulse) pulses++;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        step(3);
        // R1: reset state
        check("R1 addr_lat", addr_lat, 16'h0);
        check("R1 data_lat", data_lat, 16'h0);
        check("R1 outputs", {13'd0, wr_pulse, dq_oe, standby}, 16'h0);
        rst_n = 1; pd_n = 1;
        step(4);
        check("R8 idle standby", {15'd0, standby}, 16'h1);

        // W-controlled write, address moved at the later fall (R3, R4)
        addr_in = 16'h1000; data_in = 16'h00AA; ce_n = 0; step(3);
        addr_in = 16'h0555; we_n = 0; step(2);
        addr_in = 16'h1111; step(2);
        we_n = 1; step(1);
        data_in = 16'hBEEF; step(4);
        check("R3 W-ctl addr", addr_lat, 16'h0555);
        check("R4 W-ctl data", data_lat, 16'h00AA);
        check("R5 count", pulses[15:0], 16'd1);
        ce_n = 1; step(3);

        // E-controlled write (R4)
        we_n = 0; addr_in = 16'h2AAA; data_in = 16'h0055; step(3);
        ce_n = 0; step(4);
        ce_n = 1; step(1);
        data_in = 16'h7777; we_n = 1; step(4);
        check("R3 E-ctl addr", addr_lat, 16'h2AAA);
        check("R4 E-ctl data", data_lat, 16'h0055);
        check("R5 count", pulses[15:0], 16'd2);

        // Abort by G falling during the write (R6)
        addr_in = 16'h0F0F; data_in = 16'h3C3C; ce_n = 0; we_n = 0; step(3);
        oe_n = 0; step(3);
        ce_n = 1; we_n = 1; step(2);
        oe_n = 1; step(4);
        check("R6 abort count", pulses[15:0], 16'd2);
        check("R6 abort keeps data", data_lat, 16'h0055);

        // Back-to-back writes (R5)
        for (int i = 0; i < 2; i++) begin
            addr_in = 16'h4000 + 16'(i); data_in = 16'hA000 + 16'(i);
            ce_n = 0; we_n = 0; step(3);
            we_n = 1; step(2);
            ce_n = 1; step(1);
        end
        step(3);
        check("R5 b2b count", pulses[15:0], 16'd4);
        check("R5 b2b data", data_lat, 16'hA001);

        // Read enable latency (R2, R7)
        ce_n = 0; oe_n = 0; step(2);
        check("R2 latency not yet", {15'd0, dq_oe}, 16'h0);
        step(1);
        check("R2 R7 read drives", {15'd0, dq_oe}, 16'h1);
        ce_n = 1; step(3);
        check("R7 deselect floats", {15'd0, dq_oe}, 16'h0);
        oe_n = 1;

        // Standby with busy, and G/W ignored (R8)
        ctrl_busy = 1; step(2);
        check("R8 busy", {15'd0, standby}, 16'h0);
        ctrl_busy = 0; oe_n = 0; we_n = 0; step(4);
        check("R8 G/W ignored", {15'd0, standby}, 16'h1);
        oe_n = 1; we_n = 1; step(3);

        // Power-down clears and blocks writes (R9)
        pd_n = 0; step(4);
        check("R9 cleared addr", addr_lat, 16'h0);
        check("R9 cleared data", data_lat, 16'h0);
        ce_n = 0; we_n = 0; addr_in = 16'h5555; step(3);
        we_n = 1; step(4);
        check("R9 no pulse", pulses[15:0], 16'd4);
        ce_n = 1; pd_n = 1; step(4);
        check("R9 no pad drive", {15'd0, dq_oe}, 16'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule